// File: doc/BRIEF.md
# Bidirectional Pixel Conversion Counter

This block is the digital half of a single-slope converter that sits inside one pixel of a digital pixel sensor. While the analog ramp climbs, a ramp-step tick arrives once per step, about every ten fast clocks. On each tick the nine-bit binary count moves by one. A full ramp is 512 steps.

The count direction is chosen by two phase-start strobes. The backward strobe starts the reset-level conversion and the forward strobe starts the signal conversion. With one of each, the count left behind is the signal minus the reset level, modulo 512, so correlated double sampling is done with no subtractor.

A neighbourhood rank-order filter stops the count. When the local rank logic reports that enough neighbours have crossed the ramp, the pixel's count freezes for the rest of that phase. A bypass input turns the rank result off, and the block then behaves as a plain converter. Control pins are plain level or strobe signals. The count is a continuously valid register output with no handshake.

Top module: `pxc_counter`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the count to 0, selects forward counting and releases any freeze.
- R2: With no strobe and no freeze, each clock with `step_tick` high changes the count by exactly one in the current direction: +1 forward, −1 backward. A clock without `step_tick` leaves the count unchanged.
- R3: A `bwd_strb` pulse selects backward counting for the following ticks, clears the freeze, and leaves the count value as it was.
- R4: A `fwd_strb` pulse selects forward counting and clears the freeze. If both strobes arrive in the same clock, forward wins.
- R5: The count wraps modulo 512: 511 plus one step forward gives 0, and 0 minus one step backward gives 511.
- R6: With `bypass` low, `rank_stop` high freezes the count from that clock on. A `step_tick` in the same clock is not counted. The freeze holds until reset or the next phase strobe, so the frozen value survives a direction change.
- R7: With `bypass` high, `rank_stop` is ignored. Any freeze already stored is also masked while `bypass` stays high. A `rank_stop` seen under bypass is not remembered after bypass drops.
- R8: Starting from reset, `bwd_strb` followed by Nr ticks, then `fwd_strb` followed by Ns ticks, leaves the count at (Ns − Nr) mod 512.
- R9: A phase strobe in the same clock as `step_tick` takes priority. That tick is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| fwd_strb | input | 1 | Start of signal phase: count forward, clear freeze |
| bwd_strb | input | 1 | Start of reset-level phase: count backward, clear freeze |
| step_tick | input | 1 | One-clock qualifier, once per ramp step |
| rank_stop | input | 1 | Rank evaluation found the terminal rank; freeze the count |
| bypass | input | 1 | Ignore rank results (plain conversion) |
| count | output | 9 | Conversion count |

## Verification
Two pairs of functions can land in the same clock. One pair is a ramp tick and a rank stop. The other is a ramp tick and a phase strobe.

The bench drives each pair together on one clock. It then checks the count on the following clock edge. The tick must be dropped in both cases.

For the rank-stop pair, later ticks show whether the freeze held. For the strobe pair, the next ticks show whether the new direction took effect from the value that was held. The same coincidence is repeated with bypass high, and there the tick must count and the stop must leave no trace once bypass drops.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  localparam int unsigned PXC_WIDTH = 9;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_BWD = 1'b1
  } pxc_dir_e;
endpackage

// File: rtl/pxc_ctrl.sv
module pxc_ctrl
  import pxc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     fwd_strb,
  input  logic     bwd_strb,
  input  logic     step_tick,
  input  logic     rank_stop,
  input  logic     bypass,
  output pxc_dir_e dir,
  output logic     hold_q,
  output logic     adv
);
  logic     phase_start;
  logic     freeze_now;
  pxc_dir_e dir_q;

  assign phase_start = fwd_strb | bwd_strb;
  // a stored freeze or a fresh stop blocks counting unless bypassed
  assign freeze_now  = ~bypass & (hold_q | rank_stop);
  assign adv         = step_tick & ~phase_start & ~freeze_now;
  assign dir         = dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= DIR_FWD;
      hold_q <= 1'b0;
    end else if (phase_start) begin
      dir_q  <= fwd_strb ? DIR_FWD : DIR_BWD;
      hold_q <= 1'b0;
    end else if (rank_stop && !bypass) begin
      hold_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pxc_stage.sv
module pxc_stage
  import pxc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pxc_dir_e dir,
  input  logic     t_in,
  output logic     q,
  output logic     t_out
);
  // toggle when every lower stage is at its carry (fwd) or borrow (bwd) value
  assign t_out = t_in & ((dir == DIR_BWD) ? ~q : q);

  always_ff @(posedge clk) begin
    if (rst)       q <= 1'b0;
    else if (t_in) q <= ~q;
  end
endmodule

// File: rtl/pxc_counter.sv
module pxc_counter
  import pxc_pkg::*;
#(
  parameter int unsigned WIDTH = PXC_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fwd_strb,
  input  logic             bwd_strb,
  input  logic             step_tick,
  input  logic             rank_stop,
  input  logic             bypass,
  output logic [WIDTH-1:0] count
);
  pxc_dir_e       dir_w;
  logic           hold_w;
  logic           adv_w;
  logic [WIDTH:0] chain;

  pxc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .fwd_strb (fwd_strb),
    .bwd_strb (bwd_strb),
    .step_tick(step_tick),
    .rank_stop(rank_stop),
    .bypass   (bypass),
    .dir      (dir_w),
    .hold_q   (hold_w),
    .adv      (adv_w)
  );

  assign chain[0] = adv_w;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    pxc_stage u_stage (
      .clk  (clk),
      .rst  (rst),
      .dir  (dir_w),
      .t_in (chain[i]),
      .q    (count[i]),
      .t_out(chain[i+1])
    );
  end
endmodule

// File: rtl/pxc_counter_chk.sv
module pxc_counter_chk
  import pxc_pkg::*;
#(
  parameter int unsigned WIDTH = PXC_WIDTH
) (
  input logic             clk,
  input logic             rst,
  input logic             fwd_strb,
  input logic             bwd_strb,
  input logic             step_tick,
  input logic             rank_stop,
  input logic             bypass,
  input pxc_dir_e         dir,
  input logic             hold,
  input logic [WIDTH-1:0] count
);
  logic free_step;
  assign free_step = step_tick && !fwd_strb && !bwd_strb &&
                     (bypass || (!hold && !rank_stop));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && dir == DIR_FWD && !hold));

  assert_fwd_step_R2: assert property (@(posedge clk) disable iff (rst)
    (free_step && dir == DIR_FWD) |=> count == WIDTH'($past(count) + 1'b1));

  assert_bwd_step_R2: assert property (@(posedge clk) disable iff (rst)
    (free_step && dir == DIR_BWD) |=> count == WIDTH'($past(count) - 1'b1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step_tick |=> $stable(count));

  assert_bwd_select_R3: assert property (@(posedge clk) disable iff (rst)
    (bwd_strb && !fwd_strb) |=> (dir == DIR_BWD && !hold && $stable(count)));

  assert_fwd_wins_R4: assert property (@(posedge clk) disable iff (rst)
    fwd_strb |=> (dir == DIR_FWD && !hold));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (rank_stop && !bypass && !fwd_strb && !bwd_strb) |=> ($stable(count) && hold));

  assert_bypass_ignore_R7: assert property (@(posedge clk) disable iff (rst)
    (bypass && rank_stop && !fwd_strb && !bwd_strb) |=> $stable(hold));

  assert_strobe_priority_R9: assert property (@(posedge clk) disable iff (rst)
    (fwd_strb || bwd_strb) |=> $stable(count));
endmodule

bind pxc_counter pxc_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .fwd_strb (fwd_strb),
  .bwd_strb (bwd_strb),
  .step_tick(step_tick),
  .rank_stop(rank_stop),
  .bypass   (bypass),
  .dir      (dir_w),
  .hold     (hold_w),
  .count    (count)
);

// File: tb/pxc_counter_test.sv
module pxc_counter_test;
  localparam int W = 9;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         fwd_strb = 1'b0;
  logic         bwd_strb = 1'b0;
  logic         step_tick = 1'b0;
  logic         rank_stop = 1'b0;
  logic         bypass = 1'b0;
  logic [W-1:0] count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  pxc_counter #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .fwd_strb(fwd_strb), .bwd_strb(bwd_strb),
    .step_tick(step_tick), .rank_stop(rank_stop), .bypass(bypass),
    .count(count)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(); rst = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      step_tick = 1'b1; cyc();
    end
    step_tick = 1'b0;
  endtask

  task automatic strobe(input logic f, input logic b, input logic t);
    fwd_strb = f; bwd_strb = b; step_tick = t; cyc();
    fwd_strb = 1'b0; bwd_strb = 1'b0; step_tick = 1'b0;
  endtask

  initial begin
    cyc(); cyc(); cyc();
    rst = 1'b0;
    chk("R1 reset value", int'(count), 0);

    // forward sweep past the top, one check per tick
    for (int i = 1; i <= 600; i++) begin
      step_tick = 1'b1; cyc();
      chk("R2/R5 forward sweep", int'(count), i % M);
    end
    step_tick = 1'b0;
    cyc(); cyc();
    chk("R2 idle no change", int'(count), 600 % M);

    // backward strobe coincident with a tick: tick dropped
    strobe(1'b0, 1'b1, 1'b1);
    chk("R9/R3 strobe beats tick", int'(count), 600 % M);
    for (int i = 1; i <= 100; i++) begin
      step_tick = 1'b1; cyc();
      chk("R3/R5 backward sweep", int'(count), ((600 - i) % M + M) % M);
    end
    step_tick = 1'b0;

    // reset clears a frozen state
    rank_stop = 1'b1; cyc(); rank_stop = 1'b0;
    do_reset();
    chk("R1 reset mid-run", int'(count), 0);
    ticks(3);
    chk("R1 forward after reset", int'(count), 3);

    // CDS sweep
    for (int nr = 0; nr < M; nr += 73) begin
      for (int ns = 0; ns < M; ns += 61) begin
        do_reset();
        strobe(1'b0, 1'b1, 1'b0);
        ticks(nr);
        strobe(1'b1, 1'b0, 1'b0);
        ticks(ns);
        chk("R8 cds difference", int'(count), ((ns - nr) % M + M) % M);
      end
    end

    // rank stop coincident with a tick
    do_reset();
    ticks(20);
    rank_stop = 1'b1; step_tick = 1'b1; cyc();
    rank_stop = 1'b0; step_tick = 1'b0;
    chk("R6 stop drops same tick", int'(count), 20);
    ticks(10);
    chk("R6 freeze holds", int'(count), 20);
    strobe(1'b0, 1'b1, 1'b0);
    chk("R6 value kept over direction change", int'(count), 20);
    ticks(5);
    chk("R3 resumes backward after strobe", int'(count), 15);

    // bypass
    do_reset();
    bypass = 1'b1;
    ticks(10);
    rank_stop = 1'b1; step_tick = 1'b1; cyc();
    rank_stop = 1'b0; step_tick = 1'b0;
    chk("R7 bypass counts through stop", int'(count), 11);
    ticks(5);
    chk("R7 bypass keeps counting", int'(count), 16);
    bypass = 1'b0;
    ticks(1);
    chk("R7 stop under bypass not stored", int'(count), 17);
    rank_stop = 1'b1; cyc(); rank_stop = 1'b0;
    ticks(1);
    chk("R6 frozen without bypass", int'(count), 17);
    bypass = 1'b1;
    ticks(1);
    chk("R7 bypass masks stored freeze", int'(count), 18);
    bypass = 1'b0;
    ticks(1);
    chk("R7 stored freeze returns", int'(count), 18);

    // both strobes: forward wins
    do_reset();
    strobe(1'b0, 1'b1, 1'b0);
    ticks(1);
    chk("R5 backward wrap to top", int'(count), M - 1);
    strobe(1'b1, 1'b1, 1'b1);
    chk("R9 dual strobe drops tick", int'(count), M - 1);
    ticks(1);
    chk("R4 dual strobe picks forward", int'(count), 0);
    rank_stop = 1'b1; cyc(); rank_stop = 1'b0;
    strobe(1'b1, 1'b0, 1'b0);
    ticks(2);
    chk("R4 forward strobe clears freeze", int'(count), 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule